// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the low-order address bits of a fixed-length memory burst. On a load cycle it captures a start address from outside. On each later advance cycle it steps to the next beat. After the last beat it wraps back to the start, inside the same aligned group of addresses. The upper address bits bypass the block.

A mode input picks the beat order. In interleaved order, each beat is the start address XORed with the beat number. In linear order, each beat is the start address plus the beat number, wrapping modulo the burst length. A stall input freezes the sequencer on any edge where it is high.

A synthesized design cannot sense a floating pin. The parameter `MODE_PIN_EN` therefore stands in for an unconnected mode pin: set to 0, it fixes the order to interleaved and ignores the pin.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_ni` is low, the latched start address and the beat counter are 0, so `addr_o` reads 0.
- R2: On a rising edge with `stall_i`=0 and `adv_i`=0, the block captures `start_i` and returns to beat 0. After that edge, `addr_o` equals the captured start.
- R3: With `mode_i`=1 (interleaved), beat k of the burst drives `addr_o` = start XOR k. For example, start 01 gives 01, 00, 11, 10.
- R4: With `mode_i`=0 (linear), beat k of the burst drives `addr_o` = (start + k) modulo 2^`BEAT_BITS`. For example, start 11 gives 11, 00, 01, 10.
- R5: On a rising edge with `stall_i`=1, the block ignores `adv_i` and `start_i`, and `addr_o` keeps its value.
- R6: A burst has exactly 2^`BEAT_BITS` beats. The advance after the last beat returns to beat 0 and to the start address.
- R7: With `MODE_PIN_EN`=0, the order is interleaved whatever level `mode_i` has.
- R8: A load in the middle of a burst abandons the old burst. The next beats follow the new start address from beat 0.

Beat k counts from the most recent load: the load cycle gives beat 0, and each enabled advance after it adds one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | 1 = ignore this edge and hold the state |
| adv_i | input | 1 | 0 = load `start_i`, 1 = advance to the next beat |
| start_i | input | BEAT_BITS | Start address captured on a load |
| mode_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_o | output | BEAT_BITS | Current low-order burst address |

## Verification
The bench drives two instances from the same inputs, both with `BEAT_BITS`=2.
- The first instance has `MODE_PIN_EN`=1. It exercises both orders, including `mode_i` changes between bursts.
- The second instance has `MODE_PIN_EN`=0. With `mode_i` held low, it shows that the pin is ignored in this configuration.

At two address bits, every start value and every wrap point of the four-beat group occurs many times under random loads, advances and stalls. The directed cases start bursts at 01 and 11 and load again in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_mode_sel.sv
module bseq_mode_sel
  import burst_seq_pkg::*;
#(
  parameter bit MODE_PIN_EN = 1'b1
) (
  input  logic   mode_i,
  output order_e ord_o
);
  generate
    if (MODE_PIN_EN) begin : g_pin
      assign ord_o = mode_i ? ORD_INTERLEAVE : ORD_LINEAR;
    end else begin : g_fixed
      // unconnected pin: interleaved order
      logic unused_mode;
      assign unused_mode = mode_i;
      assign ord_o       = ORD_INTERLEAVE;
    end
  endgenerate
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic          adv_i,
  input  logic [AW-1:0] start_i,
  output logic [AW-1:0] start_q_o,
  output logic [AW-1:0] beat_q_o
);
  localparam logic [AW-1:0] LastBeat = {AW{1'b1}};

  logic [AW-1:0] start_q, beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (!stall_i) begin
      if (!adv_i) begin
        start_q <= start_i;
        beat_q  <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign start_q_o = start_q;
  assign beat_q_o  = beat_q;

  // R2 R8
  load_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !adv_i) |=> (beat_q == '0 && start_q == $past(start_i)));

  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(beat_q) && $stable(start_q)));

  // R6
  beat_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && adv_i && beat_q == LastBeat) |=> (beat_q == '0 && $stable(start_q)));
endmodule

// File: rtl/bseq_addr_map.sv
module bseq_addr_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 2
) (
  input  order_e        ord_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] beat_i,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    unique case (ord_i)
      ORD_INTERLEAVE: addr_o = start_i ^ beat_i;
      default:        addr_o = AW'(start_i + beat_i);
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned BEAT_BITS   = 2,
  parameter bit          MODE_PIN_EN = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stall_i,
  input  logic                 adv_i,
  input  logic [BEAT_BITS-1:0] start_i,
  input  logic                 mode_i,
  output logic [BEAT_BITS-1:0] addr_o
);
  localparam int unsigned AW = BEAT_BITS;

  order_e        ord;
  logic [AW-1:0] start_q, beat_q;

  bseq_mode_sel #(.MODE_PIN_EN(MODE_PIN_EN)) u_mode (
    .mode_i (mode_i),
    .ord_o  (ord)
  );

  bseq_beat_ctr #(.AW(AW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall_i),
    .adv_i     (adv_i),
    .start_i   (start_i),
    .start_q_o (start_q),
    .beat_q_o  (beat_q)
  );

  bseq_addr_map #(.AW(AW)) u_map (
    .ord_i   (ord),
    .start_i (start_q),
    .beat_i  (beat_q),
    .addr_o  (addr_o)
  );

  // R4
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && adv_i && ord == ORD_LINEAR) |=>
      (ord != ORD_LINEAR || addr_o == AW'($past(addr_o) + 1'b1)));

  // R3
  ilv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && adv_i && ord == ORD_INTERLEAVE) |=>
      (ord != ORD_INTERLEAVE ||
       (addr_o ^ $past(addr_o)) == ($past(beat_q) ^ AW'($past(beat_q) + 1'b1))));

  // R2
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !adv_i) |=> (addr_o == $past(start_i)));

  // R7
  fixed_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!MODE_PIN_EN) |-> (ord == ORD_INTERLEAVE));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int unsigned BB = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          stall_i = 1'b0;
  logic          adv_i = 1'b0;
  logic [BB-1:0] start_i = '0;
  logic          mode_i = 1'b1;
  logic [BB-1:0] addr_o, addr_fix_o;

  int checks = 0;
  int failures = 0;
  logic [BB-1:0] m_start = '0;
  logic [BB-1:0] m_beat = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.BEAT_BITS(BB), .MODE_PIN_EN(1'b1)) i_burst_addr_seq (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall_i), .adv_i(adv_i),
    .start_i(start_i), .mode_i(mode_i), .addr_o(addr_o)
  );

  burst_addr_seq #(.BEAT_BITS(BB), .MODE_PIN_EN(1'b0)) i_burst_addr_seq_fix (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall_i), .adv_i(adv_i),
    .start_i(start_i), .mode_i(mode_i), .addr_o(addr_fix_o)
  );

  function automatic logic [BB-1:0] exp_addr(logic [BB-1:0] s, logic [BB-1:0] k, logic ilv);
    return ilv ? (s ^ k) : BB'(s + k);
  endfunction

  task automatic chk(string req, logic [BB-1:0] act, logic [BB-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: addr act=%b exp=%b", req, act, exp);
    end
  endtask

  // drive at negedge, one edge, check at next negedge
  task automatic step(logic st, logic adv, logic [BB-1:0] s, logic md, string req);
    stall_i = st; adv_i = adv; start_i = s; mode_i = md;
    @(posedge clk);
    if (!st) begin
      if (!adv) begin m_start = s; m_beat = '0; end
      else m_beat = m_beat + 1'b1;
    end
    @(negedge clk);
    chk(req, addr_o, exp_addr(m_start, m_beat, md));
    chk(md ? req : "R7", addr_fix_o, exp_addr(m_start, m_beat, 1'b1));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", addr_o, 2'b00);
    chk("R1", addr_fix_o, 2'b00);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", addr_o, 2'b00);

    // R3 interleaved start 01: 01 00 11 10, then R6 wrap to 01
    step(1'b0, 1'b0, 2'b01, 1'b1, "R2");
    step(1'b0, 1'b1, 2'b10, 1'b1, "R3");
    chk("R3", addr_o, 2'b00);
    step(1'b0, 1'b1, 2'b10, 1'b1, "R3");
    chk("R3", addr_o, 2'b11);
    step(1'b0, 1'b1, 2'b10, 1'b1, "R3");
    chk("R3", addr_o, 2'b10);
    step(1'b0, 1'b1, 2'b10, 1'b1, "R6");
    chk("R6", addr_o, 2'b01);

    // R4 linear start 11: 11 00 01 10, wrap
    step(1'b0, 1'b0, 2'b11, 1'b0, "R2");
    chk("R2", addr_o, 2'b11);
    step(1'b0, 1'b1, 2'b00, 1'b0, "R4");
    chk("R4", addr_o, 2'b00);
    step(1'b0, 1'b1, 2'b00, 1'b0, "R4");
    chk("R4", addr_o, 2'b01);
    // R5 stall ignores load and advance
    step(1'b1, 1'b0, 2'b10, 1'b0, "R5");
    chk("R5", addr_o, 2'b01);
    step(1'b1, 1'b1, 2'b10, 1'b0, "R5");
    chk("R5", addr_o, 2'b01);
    step(1'b0, 1'b1, 2'b00, 1'b0, "R4");
    chk("R4", addr_o, 2'b10);
    step(1'b0, 1'b1, 2'b00, 1'b0, "R6");
    chk("R6", addr_o, 2'b11);
    // R7: fixed instance interleaves with mode_i low
    chk("R7", addr_fix_o, 2'b11);
    step(1'b0, 1'b1, 2'b00, 1'b0, "R7");
    chk("R7", addr_fix_o, 2'b10);

    // R8 mid-burst reload
    step(1'b0, 1'b0, 2'b10, 1'b1, "R8");
    step(1'b0, 1'b1, 2'b00, 1'b1, "R8");
    step(1'b0, 1'b0, 2'b01, 1'b1, "R8");
    chk("R8", addr_o, 2'b01);
    step(1'b0, 1'b1, 2'b00, 1'b1, "R8");
    chk("R8", addr_o, 2'b00);

    for (int i = 0; i < 400; i++) begin
      logic st, adv, md;
      logic [BB-1:0] s;
      st  = ($urandom_range(0, 7) == 0);
      adv = ($urandom_range(0, 4) != 0);
      s   = BB'($urandom);
      md  = (i / 50) % 2 == 0;
      step(st, adv, s, md, st ? "R5" : (!adv ? "R2" : (md ? "R3" : "R4")));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule